// File: doc/BRIEF.md
# Double-Precision Funnel Shifter

This block is the double-operand shift unit of a CPU execution stage. It shifts a destination word left or right by a count. The bit positions that the shift empties are filled from a second, independent source word. In a left shift, the high bits of the source enter at the bottom of the destination. In a right shift, the low bits of the source enter at the top. The count comes either from an 8-bit immediate or from an 8-bit count register. Only its low five bits are used.

The unit also updates the status flags. Carry, overflow, zero, sign and parity are derived from the shift. The auxiliary-carry flag passes through unchanged. A masked count of zero makes the operation a no-op: nothing is written and every flag keeps the value it came in with. Decode and memory sequencing stay outside the block. An operation is started by a single-cycle valid strobe. The registered result, flags and write-enable appear one cycle later, together with a one-cycle done pulse.

Top module: `dfs_shift_unit`

## Requirements
- R1: The effective count n is the low 5 bits of `imm_i` when `cnt_from_reg_i` is 0, and the low 5 bits of `cnt_reg_i` when it is 1. The upper 3 bits of both count inputs have no effect.
- R2: When n is 0, `wr_en_o` is 0, `result_o` equals the incoming `dest_i`, and `flags_o` equals the incoming `flags_i` in every bit.
- R3: A left shift (`dir_right_i` = 0) with n ≥ 1 gives result = (dest << n) | (src >> (32 − n)) and asserts `wr_en_o`.
- R4: A right shift (`dir_right_i` = 1) with n ≥ 1 gives result = (dest >> n) | (src << (32 − n)) and asserts `wr_en_o`.
- R5: The carry flag (flags bit 0) is the last destination bit shifted out. For a left shift that is dest bit 32 − n; for a right shift it is dest bit n − 1.
- R6: The overflow flag (flags bit 5) is result bit 31 XOR dest bit 31 when n = 1. For any other nonzero n it keeps its incoming value.
- R7: The zero flag (flags bit 3) is 1 exactly when the result is zero. The sign flag (flags bit 4) equals result bit 31.
- R8: The parity flag (flags bit 1) is 1 when the low byte of the result holds an even number of 1 bits.
- R9: The auxiliary-carry flag (flags bit 2) always keeps its incoming value.
- R10: Result, flags and `wr_en_o` are registered one clock after `in_valid` is sampled high, and `done_o` is high in exactly that cycle. In a cycle after one with `in_valid` low, `done_o` and `wr_en_o` are 0 and `result_o` and `flags_o` hold their values.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| dest_i | input | 32 | Destination operand |
| src_i | input | 32 | Fill source operand |
| dir_right_i | input | 1 | 0 = left shift, 1 = right shift |
| cnt_from_reg_i | input | 1 | 0 = count from immediate, 1 = count from count register |
| imm_i | input | 8 | Immediate count byte |
| cnt_reg_i | input | 8 | Count register byte |
| flags_i | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| result_o | output | 32 | Registered shift result |
| wr_en_o | output | 1 | Result is to be written back |
| flags_o | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a nonzero byte on the count inputs whose low five bits are zero. Such a byte must still take the full no-op path: no write, and all flags returned as they came in. The stimulus reaches it through both count sources. It gives the immediate the value 0x20 and the count register the value 0xC0, with the unused source holding a nonzero count each time, and it gives an odd, distinctive incoming flag pattern so that a dropped or recomputed flag shows up. Separate vectors reach n = 1 and n = 31 in each direction, so both the overflow update and the far edge of the source fill are covered.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
    localparam int FLAG_W = 6;
    localparam int F_CF   = 0;
    localparam int F_PF   = 1;
    localparam int F_AF   = 2;
    localparam int F_ZF   = 3;
    localparam int F_SF   = 4;
    localparam int F_OF   = 5;
endpackage

// File: rtl/dfs_count_sel.sv
module dfs_count_sel #(
    parameter int SRC_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             from_reg,
    input  logic [SRC_W-1:0] imm,
    input  logic [SRC_W-1:0] creg,
    output logic [CNT_W-1:0] cnt
);
    logic [SRC_W-1:0] pick;

    always_comb begin
        pick = from_reg ? creg : imm;
        cnt  = CNT_W'(pick);
    end
endmodule

// File: rtl/dfs_funnel.sv
module dfs_funnel #(
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] dest,
    input  logic [WIDTH-1:0] src,
    input  logic             right,
    input  logic [CNT_W-1:0] cnt,
    output logic [WIDTH-1:0] res,
    output logic             carry
);
    // WIDTH must be a power of two: a shift by (WIDTH - n) is built as a
    // shift by one followed by a shift by ~n, which yields zero fill at n = 0.
    logic [CNT_W-1:0] idx_left;
    logic [CNT_W-1:0] idx_right;

    always_comb begin
        idx_left  = CNT_W'(0) - cnt;
        idx_right = cnt - CNT_W'(1);
        if (right) begin
            res   = (dest >> cnt) | ((src << 1) << (~cnt));
            carry = dest[idx_right];
        end else begin
            res   = (dest << cnt) | ((src >> 1) >> (~cnt));
            carry = dest[idx_left];
        end
    end
endmodule

// File: rtl/dfs_flag_gen.sv
module dfs_flag_gen #(
    parameter int WIDTH = 32,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]           res,
    input  logic                       carry,
    input  logic                       dest_msb,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [dfs_pkg::FLAG_W-1:0] flags_in,
    output logic [dfs_pkg::FLAG_W-1:0] flags_out
);
    import dfs_pkg::*;

    always_comb begin
        flags_out       = flags_in;
        flags_out[F_CF] = carry;
        flags_out[F_PF] = ~^res[7:0];
        flags_out[F_ZF] = (res == '0);
        flags_out[F_SF] = res[WIDTH-1];
        if (cnt == CNT_W'(1)) begin
            flags_out[F_OF] = res[WIDTH-1] ^ dest_msb;
        end
    end
endmodule

// File: rtl/dfs_shift_unit.sv
module dfs_shift_unit #(
    parameter int WIDTH = 32,
    parameter int CSRC_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [WIDTH-1:0]           dest_i,
    input  logic [WIDTH-1:0]           src_i,
    input  logic                       dir_right_i,
    input  logic                       cnt_from_reg_i,
    input  logic [CSRC_W-1:0]          imm_i,
    input  logic [CSRC_W-1:0]          cnt_reg_i,
    input  logic [dfs_pkg::FLAG_W-1:0] flags_i,
    output logic [WIDTH-1:0]           result_o,
    output logic                       wr_en_o,
    output logic [dfs_pkg::FLAG_W-1:0] flags_o,
    output logic                       done_o
);
    import dfs_pkg::*;

    localparam int CNT_W = $clog2(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0]  result;
        logic [FLAG_W-1:0] flags;
        logic              we;
        logic              done;
    } stage_t;

    stage_t state_d, state_q;

    logic [CNT_W-1:0]  cnt;
    logic [WIDTH-1:0]  shifted;
    logic              carry;
    logic [FLAG_W-1:0] new_flags;

    dfs_count_sel #(.SRC_W(CSRC_W), .CNT_W(CNT_W)) u_cnt (
        .from_reg (cnt_from_reg_i),
        .imm      (imm_i),
        .creg     (cnt_reg_i),
        .cnt      (cnt)
    );

    dfs_funnel #(.WIDTH(WIDTH)) u_funnel (
        .dest  (dest_i),
        .src   (src_i),
        .right (dir_right_i),
        .cnt   (cnt),
        .res   (shifted),
        .carry (carry)
    );

    dfs_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .res       (shifted),
        .carry     (carry),
        .dest_msb  (dest_i[WIDTH-1]),
        .cnt       (cnt),
        .flags_in  (flags_i),
        .flags_out (new_flags)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = in_valid;
        state_d.we   = 1'b0;
        if (in_valid) begin
            if (cnt != '0) begin
                state_d.result = shifted;
                state_d.flags  = new_flags;
                state_d.we     = 1'b1;
            end else begin
                state_d.result = dest_i;
                state_d.flags  = flags_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign flags_o  = state_q.flags;
    assign wr_en_o  = state_q.we;
    assign done_o   = state_q.done;

    a_r2_zero_count_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt == '0) |=> (!wr_en_o && flags_o == $past(flags_i)
                                     && result_o == $past(dest_i)));

    a_r10_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done_o && !wr_en_o && $stable(result_o) && $stable(flags_o)));

    a_r9_aux_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> flags_o[F_AF] == $past(flags_i[F_AF]));

    a_r6_of_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cnt > CNT_W'(1)) |=> flags_o[F_OF] == $past(flags_i[F_OF]));

    a_r7_sign_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> flags_o[F_SF] == result_o[WIDTH-1]);

    a_r7_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> flags_o[F_ZF] == (result_o == '0));

    a_r10_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o);
endmodule

// File: tb/tb_dfs_shift_unit.sv
module tb_dfs_shift_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] dest_i = '0;
    logic [31:0] src_i = '0;
    logic        dir_right_i = 1'b0;
    logic        cnt_from_reg_i = 1'b0;
    logic [7:0]  imm_i = '0;
    logic [7:0]  cnt_reg_i = '0;
    logic [5:0]  flags_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [5:0]  flags_o;
    logic        done_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dfs_shift_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dest_i(dest_i),
        .src_i(src_i), .dir_right_i(dir_right_i), .cnt_from_reg_i(cnt_from_reg_i),
        .imm_i(imm_i), .cnt_reg_i(cnt_reg_i), .flags_i(flags_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [31:0] dest;
        logic [31:0] src;
        logic        right;
        logic        from_reg;
        logic [7:0]  imm;
        logic [7:0]  creg;
        logic [5:0]  flags;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 32'h9ABCDEF0, 1'b0, 1'b0, 8'h04, 8'h00, 6'b000000},
        '{32'h12345678, 32'h9ABCDEF0, 1'b1, 1'b0, 8'h08, 8'h11, 6'b000100},
        '{32'hF0F0F0F0, 32'hA5A5A5A5, 1'b0, 1'b1, 8'h00, 8'h23, 6'b111111},
        '{32'h40000000, 32'h80000000, 1'b0, 1'b0, 8'hE1, 8'h07, 6'b000000},
        '{32'h80000001, 32'h00000000, 1'b1, 1'b0, 8'h01, 8'h00, 6'b000000},
        '{32'h00000003, 32'hFFFFFFFE, 1'b0, 1'b0, 8'h1F, 8'h00, 6'b100000},
        '{32'hDEADBEEF, 32'h01234567, 1'b0, 1'b0, 8'h20, 8'h05, 6'b101101},
        '{32'hCAFEF00D, 32'h76543210, 1'b1, 1'b1, 8'h05, 8'hC0, 6'b010110},
        '{32'h0000000F, 32'h00000000, 1'b1, 1'b0, 8'h04, 8'h00, 6'b000000},
        '{32'h80000000, 32'h00000001, 1'b1, 1'b1, 8'h00, 8'h3F, 6'b100000},
        '{32'h0000FFFF, 32'h00FF0000, 1'b0, 1'b1, 8'h01, 8'h90, 6'b000010},
        '{32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b0, 8'h01, 8'h00, 6'b000000}
    };

    // Independent reference built bit by bit from the requirement text.
    function automatic void model(input vec_t v, output logic [31:0] res,
                                  output logic [5:0] fl, output logic we);
        int n;
        n  = v.from_reg ? int'(v.creg % 32) : int'(v.imm % 32);
        fl = v.flags;
        if (n == 0) begin
            res = v.dest;
            we  = 1'b0;
            return;
        end
        we = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (!v.right) res[i] = (i - n >= 0) ? v.dest[i - n] : v.src[32 + i - n];
            else          res[i] = (i + n < 32) ? v.dest[i + n] : v.src[i + n - 32];
        end
        fl[0] = v.right ? v.dest[n - 1] : v.dest[32 - n];
        begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(res[b]);
            fl[1] = (ones % 2 == 0);
        end
        fl[3] = (res == 32'h0);
        fl[4] = res[31];
        if (n == 1) fl[5] = res[31] ^ v.dest[31];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        dest_i = v.dest; src_i = v.src; dir_right_i = v.right;
        cnt_from_reg_i = v.from_reg; imm_i = v.imm; cnt_reg_i = v.creg;
        flags_i = v.flags;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] exp_res;
        logic [5:0]  exp_fl;
        logic        exp_we;
        logic [31:0] last_res;
        logic [5:0]  last_fl;

        repeat (3) @(negedge clk);
        // R11: outputs held at zero during reset
        chk("R11 result", result_o, 32'h0);
        chk("R11 flags", {26'h0, flags_o}, 32'h0);
        chk("R11 done/we", {30'h0, done_o, wr_en_o}, 32'h0);
        rst_n = 1'b1;

        // Table walk: R1..R9 per vector, R10 timing on each
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k]);
            in_valid = 1'b1;
            model(VECS[k], exp_res, exp_fl, exp_we);
            @(negedge clk);
            in_valid = 1'b0;
            chk($sformatf("R3/R4/R1/R2 result v%0d", k), result_o, exp_res);
            chk($sformatf("R5/R6/R7/R8/R9 flags v%0d", k), {26'h0, flags_o}, {26'h0, exp_fl});
            chk($sformatf("R2 write enable v%0d", k), {31'h0, wr_en_o}, {31'h0, exp_we});
            chk($sformatf("R10 done pulse v%0d", k), {31'h0, done_o}, 32'h1);
        end

        // R10: idle cycle keeps outputs and drops strobes
        last_res = result_o;
        last_fl  = flags_o;
        dest_i = 32'h55555555;
        flags_i = 6'b111111;
        @(negedge clk);
        chk("R10 idle done", {31'h0, done_o}, 32'h0);
        chk("R10 idle we", {31'h0, wr_en_o}, 32'h0);
        chk("R10 idle result hold", result_o, last_res);
        chk("R10 idle flags hold", {26'h0, flags_o}, {26'h0, last_fl});

        // R10: back-to-back operations, each one cycle later
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        model(VECS[0], exp_res, exp_fl, exp_we);
        chk("R10 back-to-back first", result_o, exp_res);
        drive(VECS[1]);
        @(negedge clk);
        in_valid = 1'b0;
        model(VECS[1], exp_res, exp_fl, exp_we);
        chk("R10 back-to-back second", result_o, exp_res);
        chk("R10 back-to-back done", {31'h0, done_o}, 32'h1);

        // R11: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 re-reset result", result_o, 32'h0);
        chk("R11 re-reset flags", {26'h0, flags_o}, 32'h0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule